// File: doc/BRIEF.md
# E1 Timeslot-0 Spare-Bit Inserter

This block sits in the transmit path of an E1 framer, after the stage that builds timeslot 0. It holds eight host-written 8-bit source registers: the international bit for alignment frames, the international bit for non-alignment frames, the remote alarm bit, and the five national bits Sa4 to Sa8. It also holds an 8-bit enable register. At the transmit multiframe boundary, which is the strobe for frame 0, all eight sources are copied into working shift registers. Over the 16 frames that follow, each source supplies one bit per frame of its parity, most significant bit first. Where a source's enable is set, its bit replaces the matching timeslot-0 position. Where the enable is clear, the upstream byte passes through unchanged.

Frame alignment words and CRC generation are handled upstream. Frames must arrive in order, 0 to 15, one strobe per frame. The host has a full multiframe to change a source. A source left unchanged is sent again on the next multiframe.

Top module: `e1_spare_ins`

## Requirements
- R1: After reset, `ts0_out`, `out_valid` and `mf_sample` are 0. All source registers and the enable register are 0, so every byte passes through unchanged.
- R2: With an enable register of 0, `ts0_out` equals the `ts0_in` presented with the strobe, in every frame.
- R3: Each `frm_strobe` produces its `ts0_out` byte and a one-cycle `out_valid` exactly one clock later. `out_valid` never rises without a strobe.
- R4: In an even frame 2k with enable bit 0 set, output bit 7 is bit 7-k of the alignment-frame international register (address 0). Bits 6..0 always pass through in even frames.
- R5: In an odd frame 2k+1, bit 7-k of each of the following registers replaces a single output position when its enable bit is set:
  - international, non-alignment (address 1, enable 1): output bit 7
  - remote alarm (address 2, enable 2): output bit 5
  - Sa4 to Sa8 (addresses 3 to 7, enables 3 to 7): output bits 4 down to 0
- R6: Output bit 6 is never altered.
- R7: The sources are sampled at the frame-0 strobe. `mf_sample` pulses one clock after that strobe and at no other time.
- R8: A source write made after the frame-0 strobe does not change the current multiframe. It appears from the next frame 0 onward.
- R9: A source write in the same cycle as the frame-0 strobe is not sampled at that strobe. It is sampled at the following boundary.
- R10: A source not rewritten is sent identically on the next multiframe.
- R11: Address 8 writes the enable register, which takes effect from the next strobe. Writes to addresses 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_strobe | input | 1 | One-cycle pulse per frame |
| frm_num | input | 4 | Frame number within the multiframe, valid with the strobe |
| ts0_in | input | 8 | Upstream timeslot-0 byte, bit 7 sent first |
| wr_en | input | 1 | Host write enable |
| wr_addr | input | 4 | Host write address (0-7 sources, 8 enables) |
| wr_data | input | 8 | Host write data |
| ts0_out | output | 8 | Timeslot-0 byte with spare bits inserted |
| out_valid | output | 1 | `ts0_out` is valid this cycle |
| mf_sample | output | 1 | Pulse: sources were sampled for a new multiframe |

## Verification
A working shift register that loads at the wrong moment, or shifts on frames of the wrong parity, shows up as a wrong inserted bit within one or two frames of the fault. The frame-0 check catches an early or late load at the boundary itself. A write that leaks into the multiframe in flight changes an inserted bit in the very next frame of that source's parity. Checking all 16 frames of each multiframe shows such a leak within a single multiframe. An enable wired to the wrong position flips a passed-through upstream bit on the first strobe of the affected parity.

// File: rtl/e1sb_pkg.sv
// Package: shared constants and the timeslot-0 position map for the
// spare-bit inserter. Assumes the E1 timeslot-0 layout with bit 7 sent first.
package e1sb_pkg;
    localparam int NSRC   = 8;   // number of spare-bit sources
    localparam int TS_W   = 8;   // timeslot byte width
    localparam int SRC_SI_ALN = 0;   // only source carried in even frames

    // Output bit position that source s occupies in its frame.
    function automatic int slot_pos(input int s);
        if (s <= 1)      return 7;       // international bits
        else if (s == 2) return 5;       // remote alarm
        else             return 7 - s;   // Sa4..Sa8 -> 4..0
    endfunction

    // True when source s is carried in even (alignment) frames.
    function automatic bit in_even(input int s);
        return (s == SRC_SI_ALN);
    endfunction
endpackage

// File: rtl/e1sb_hostregs.sv
// Module: host-written source registers and the per-source enable register.
// Assumes addresses 0..NSRC-1 select sources, NSRC selects enables, the rest
// are unused. Writes land on the clock edge where wr_en is high.
module e1sb_hostregs #(
    parameter int NSRC  = 8,
    parameter int REG_W = 8,
    parameter int AW    = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [AW-1:0]                   wr_addr,
    input  logic [REG_W-1:0]                wr_data,
    output logic [NSRC-1:0][REG_W-1:0]      host_q,
    output logic [NSRC-1:0]                 ctrl_q
);
    localparam logic [AW-1:0] CTRL_ADDR = AW'(NSRC);

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        localparam logic [AW-1:0] MY_ADDR = AW'(s);
        // Hold one source register, replaced on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                host_q[s] <= '0;
            else if (wr_en && wr_addr == MY_ADDR)
                host_q[s] <= wr_data;
        end
    end

    // Hold the enable register, replaced on a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && wr_addr == CTRL_ADDR)
            ctrl_q <= wr_data[NSRC-1:0];
    end
endmodule

// File: rtl/e1sb_bitseq.sv
// Module: working shift registers, one per source. Each loads from its host
// register at the frame-0 strobe and shifts once per frame of its parity.
// Assumes frames arrive in order, one strobe per frame. In frame 0 the
// alignment source reads its host register directly, since that frame uses
// the value being sampled.
module e1sb_bitseq
    import e1sb_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int REG_W = 8,
    parameter int FN_W  = $clog2(2 * REG_W)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frm_strobe,
    input  logic [FN_W-1:0]             frm_num,
    input  logic [NSRC-1:0][REG_W-1:0]  host_q,
    output logic [NSRC-1:0]             cur_bit
);
    logic boundary;
    logic odd_frame;
    logic [NSRC-1:0][REG_W-1:0] work_q;

    assign boundary  = frm_strobe && (frm_num == '0);
    assign odd_frame = frm_num[0];

    for (genvar s = 0; s < NSRC; s++) begin : g_seq
        if (in_even(s)) begin : g_even
            // Alignment source: load pre-shifted at frame 0, shift on even frames.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    work_q[s] <= '0;
                else if (boundary)
                    work_q[s] <= host_q[s] << 1;
                else if (frm_strobe && !odd_frame)
                    work_q[s] <= work_q[s] << 1;
            end
            assign cur_bit[s] = (frm_num == '0) ? host_q[s][REG_W-1]
                                                : work_q[s][REG_W-1];
        end else begin : g_odd
            // Odd-frame source: load at frame 0, shift after each odd frame.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    work_q[s] <= '0;
                else if (boundary)
                    work_q[s] <= host_q[s];
                else if (frm_strobe && odd_frame)
                    work_q[s] <= work_q[s] << 1;
            end
            assign cur_bit[s] = work_q[s][REG_W-1];
        end
    end
endmodule

// File: rtl/e1sb_merge.sv
// Module: overlays enabled source bits on the upstream timeslot-0 byte and
// registers the result. Assumes cur_bit is valid in the strobe cycle.
module e1sb_merge
    import e1sb_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int TW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frm_strobe,
    input  logic            boundary,
    input  logic            odd_frame,
    input  logic [TW-1:0]   ts0_in,
    input  logic [NSRC-1:0] cur_bit,
    input  logic [NSRC-1:0] ctrl_q,
    output logic [TW-1:0]   ts0_out,
    output logic            out_valid,
    output logic            mf_sample
);
    logic [TW-1:0] merged;

    // Replace each enabled position whose source belongs to this frame parity.
    always_comb begin
        merged = ts0_in;
        for (int s = 0; s < NSRC; s++) begin
            if (ctrl_q[s] && (in_even(s) != odd_frame))
                merged[slot_pos(s)] = cur_bit[s];
        end
    end

    // Register the byte and the strobe-aligned flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts0_out   <= '0;
            out_valid <= 1'b0;
            mf_sample <= 1'b0;
        end else begin
            out_valid <= frm_strobe;
            mf_sample <= boundary;
            if (frm_strobe)
                ts0_out <= merged;
        end
    end
endmodule

// File: rtl/e1_spare_ins.sv
// Module: top of the E1 timeslot-0 spare-bit inserter. Ties together the host
// registers, the per-source bit sequencers and the output merge.
// Assumes an in-order frame strobe with frm_num valid alongside it.
module e1_spare_ins
    import e1sb_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int AW    = 4,
    parameter int FN_W  = $clog2(2 * REG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_strobe,
    input  logic [FN_W-1:0]   frm_num,
    input  logic [TS_W-1:0]   ts0_in,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [TS_W-1:0]   ts0_out,
    output logic              out_valid,
    output logic              mf_sample
);
    logic [NSRC-1:0][REG_W-1:0] host_q;
    logic [NSRC-1:0]            ctrl_q;
    logic [NSRC-1:0]            cur_bit;
    logic                       boundary;

    assign boundary = frm_strobe && (frm_num == '0);

    e1sb_hostregs #(.NSRC(NSRC), .REG_W(REG_W), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .host_q(host_q), .ctrl_q(ctrl_q)
    );

    e1sb_bitseq #(.NSRC(NSRC), .REG_W(REG_W), .FN_W(FN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .frm_strobe(frm_strobe),
        .frm_num(frm_num), .host_q(host_q), .cur_bit(cur_bit)
    );

    e1sb_merge #(.NSRC(NSRC), .TW(TS_W)) u_merge (
        .clk(clk), .rst_n(rst_n), .frm_strobe(frm_strobe),
        .boundary(boundary), .odd_frame(frm_num[0]), .ts0_in(ts0_in),
        .cur_bit(cur_bit), .ctrl_q(ctrl_q), .ts0_out(ts0_out),
        .out_valid(out_valid), .mf_sample(mf_sample)
    );
endmodule

// File: rtl/e1sb_chk.sv
// Module: assertion checker for e1_spare_ins, attached by bind below.
// Assumes it observes the top's ports and its enable register.
module e1sb_chk #(
    parameter int FN_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frm_strobe,
    input logic [FN_W-1:0] frm_num,
    input logic [7:0]      ts0_in,
    input logic [7:0]      ts0_out,
    input logic            out_valid,
    input logic            mf_sample,
    input logic [7:0]      ctrl_q
);
    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        frm_strobe |=> out_valid); // R3
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(frm_strobe)); // R3
    AST_BIT6_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ts0_out[6] == $past(ts0_in[6])); // R6
    AST_EVEN_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(frm_num[0])) |-> ts0_out[6:0] == $past(ts0_in[6:0])); // R4
    AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(ctrl_q) == 8'h00) |-> ts0_out == $past(ts0_in)); // R2
    AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mf_sample |-> $past(frm_strobe && frm_num == '0)); // R7
    AST_SAMPLE_FOLLOWS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_strobe && frm_num == '0) |=> mf_sample); // R7
endmodule

bind e1_spare_ins e1sb_chk #(.FN_W(FN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frm_strobe(frm_strobe), .frm_num(frm_num),
    .ts0_in(ts0_in), .ts0_out(ts0_out), .out_valid(out_valid),
    .mf_sample(mf_sample), .ctrl_q(ctrl_q)
);

// File: tb/e1_spare_ins_tb.sv
module e1_spare_ins_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_strobe = 1'b0;
    logic [3:0] frm_num = '0;
    logic [7:0] ts0_in = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] ts0_out;
    logic       out_valid;
    logic       mf_sample;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] shadow [8];
    logic [7:0] snap [8];
    logic [7:0] sh_ctrl = '0;

    always #10 clk = ~clk;   // 50 MHz

    e1_spare_ins u_dut (
        .clk(clk), .rst_n(rst_n), .frm_strobe(frm_strobe), .frm_num(frm_num),
        .ts0_in(ts0_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ts0_out(ts0_out), .out_valid(out_valid), .mf_sample(mf_sample)
    );

    // Vector table: {enables, source seed, upstream byte}
    localparam logic [23:0] VEC [5] = '{
        {8'h00, 8'hA5, 8'h1B},
        {8'hFF, 8'h3C, 8'h00},
        {8'h01, 8'h96, 8'hFF},
        {8'hFE, 8'h5A, 8'hC3},
        {8'h2D, 8'hE1, 8'h66}
    };

    function automatic int pos_of(input int s);
        if (s <= 1) return 7;
        if (s == 2) return 5;
        return 7 - s;
    endfunction

    // Expected byte for frame f from the requirement text (R2, R4, R5, R6).
    function automatic logic [7:0] model(input int f, input logic [7:0] tin,
                                         input logic [7:0] en);
        logic [7:0] e = tin;
        int k = f / 2;
        if (f % 2 == 0) begin
            if (en[0]) e[7] = snap[0][7-k];
        end else begin
            for (int s = 1; s < 8; s++)
                if (en[s]) e[pos_of(s)] = snap[s][7-k];
        end
        return e;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One frame, optionally with a host write in the strobe cycle.
    task automatic do_frame(input int f, input logic [7:0] tin, input bit wr,
                            input logic [3:0] a, input logic [7:0] d, input bit chk);
        logic [7:0] en_used;
        @(negedge clk);
        frm_strobe = 1'b1; frm_num = 4'(f); ts0_in = tin;
        wr_en = wr; wr_addr = a; wr_data = d;
        if (f == 0) snap = shadow;
        en_used = sh_ctrl;
        if (wr && a < 8) shadow[a] = d;
        if (wr && a == 8) sh_ctrl = d;
        @(negedge clk);
        frm_strobe = 1'b0; wr_en = 1'b0;
        if (chk) begin
            check((en_used == 0) ? "R2" : ((f % 2 == 0) ? "R4" : "R5"),
                  ts0_out, model(f, tin, en_used));
            check("R3", {7'b0, out_valid}, 8'h01);
            if (f <= 1) check("R7", {7'b0, mf_sample}, (f == 0) ? 8'h01 : 8'h00);
        end
    endtask

    task automatic host_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        if (a < 8) shadow[a] = d;
        if (a == 8) sh_ctrl = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_mf(input logic [7:0] tin);
        for (int f = 0; f < 16; f++) do_frame(f, tin ^ 8'(f * 8'h13), 0, 0, 0, 1);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin shadow[i] = '0; snap[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", ts0_out, 8'h00);
        check("R1", {6'b0, out_valid, mf_sample}, 8'h00);
        run_mf(8'h5E);   // R1: registers zero, pass-through

        // Table walk
        for (int v = 0; v < 5; v++) begin
            for (int s = 0; s < 8; s++)
                host_write(4'(s), VEC[v][15:8] ^ 8'(s * 8'h29) ^ 8'(s << 5));
            host_write(4'd8, VEC[v][23:16]);
            run_mf(VEC[v][7:0]);
        end

        // R10: no rewrite -> same bits again
        host_write(4'd8, 8'hFF);
        run_mf(8'h00);
        run_mf(8'h00);   // R10 snap unchanged since shadow unchanged

        // R8: write mid-multiframe does not touch current multiframe
        for (int f = 0; f < 16; f++) begin
            if (f == 5) begin
                do_frame(f, 8'h00, 1, 4'd0, 8'h0F, 1);   // R8
            end else if (f == 6) begin
                do_frame(f, 8'h00, 1, 4'd4, 8'hF0, 1);   // R8
            end else begin
                do_frame(f, 8'h00, 0, 0, 0, 1);
            end
        end
        run_mf(8'h00);   // R8: new values now visible

        // R9: write in the frame-0 strobe cycle is deferred
        do_frame(0, 8'h00, 1, 4'd0, 8'h80, 1);   // R9 (snap taken before write)
        for (int f = 1; f < 16; f++) do_frame(f, 8'h00, 1, 4'd3, 8'h3C, 1);
        run_mf(8'h00);   // R9: 8'h80 now sampled

        // R11: unused addresses ignored, enable register untouched
        host_write(4'd9, 8'h00);
        host_write(4'd12, 8'h00);
        host_write(4'd15, 8'h55);
        run_mf(8'h00);   // R11: model uses unchanged shadow and enables

        // R11: enable write takes effect from the next strobe
        host_write(4'd8, 8'h00);
        run_mf(8'hA7);

        // R3: no valid without a strobe
        @(negedge clk);
        check("R3", {7'b0, out_valid}, 8'h00);
        check("R7", {7'b0, mf_sample}, 8'h00);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule